// File: doc/BRIEF.md
# Core-to-System Address Translation Unit

This unit sits between one processor core and the on-chip network of a two-core tile. It turns each 32-bit core address into a system request. The top byte of the address selects one row of a writable 256-row map. Each row holds four fields: a bypass flag, an 8-bit tile coordinate (Y in bits [7:4], X in bits [3:0]), a 3-bit on-tile target code and a 10-bit memory prefix. The low 24 address bits pass straight through. The prefix is placed above them to form a 34-bit system address.

Every request is sorted into one of three classes. Each class feeds its own FIFO with a valid/ready pair: off-chip memory, message-buffer or local configuration register. A write port loads map rows one at a time. Each core has its own instance of the unit, and so its own map. The target codes are 0 core0, 1 core1, 2 configuration block, 3 message buffer, 4 east, 5 south, 6 west and 7 north.

Top module: `addr_xlate_unit`

## Requirements
- R1: After reset all three queue outputs are invalid, `req_ready` is high, and every map row is zero. A request therefore lands in the memory queue with tile 0, target 0 and address `{10'b0, addr[23:0]}`.
- R2: `req_addr[31:24]` selects the map row, and `req_addr[23:0]` appears unchanged in the low 24 bits of the output address.
- R3: Every queued request carries the 34-bit address `{prefix, req_addr[23:0]}`, together with the row's target code.
- R4: A row with bypass set sends the request to the message-buffer queue. The tile field it carries is then `LOCAL_TILE`, whatever tile the row holds.
- R5: A row with bypass clear and target 3 sends the request to the message-buffer queue, carrying the row's tile.
- R6: A row with bypass clear, target 2 and tile equal to `LOCAL_TILE` goes to the configuration queue. Target 2 with any other tile goes to the memory queue.
- R7: Every remaining case goes to the memory queue. This covers targets 0, 1 and 4 to 7, and remote target 2. Each accepted request enters exactly one queue.
- R8: Each queue holds `QDEPTH` (4) entries. `req_ready` is low only while the queue that the current address selects is full. A full queue is never written, and requests to the other queues are still accepted.
- R9: Within a queue, requests leave in the order they were accepted. A head that is held by a low ready stays stable.
- R10: A map write issued in the same cycle as an accepted request does not affect that request. It applies to every request accepted from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Map row write strobe |
| tbl_idx | input | 8 | Row being written |
| tbl_bypass | input | 1 | Bypass flag for the row |
| tbl_dest | input | 8 | Tile coordinate {Y,X} for the row |
| tbl_sub | input | 3 | On-tile target code for the row |
| tbl_pfx | input | 10 | Memory prefix for the row |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | 32 | Core address |
| dram_valid | output | 1 | Memory queue head valid |
| dram_ready | input | 1 | Memory queue pop |
| dram_dest | output | 8 | Memory queue head tile |
| dram_sub | output | 3 | Memory queue head target code |
| dram_addr | output | 34 | Memory queue head system address |
| mbuf_valid | output | 1 | Message-buffer queue head valid |
| mbuf_ready | input | 1 | Message-buffer queue pop |
| mbuf_dest | output | 8 | Message-buffer queue head tile |
| mbuf_sub | output | 3 | Message-buffer queue head target code |
| mbuf_addr | output | 34 | Message-buffer queue head system address |
| cfg_valid | output | 1 | Configuration queue head valid |
| cfg_ready | input | 1 | Configuration queue pop |
| cfg_dest | output | 8 | Configuration queue head tile |
| cfg_sub | output | 3 | Configuration queue head target code |
| cfg_addr | output | 34 | Configuration queue head system address |

## Verification
The bench loads all 256 rows with values derived from the row number and sends one request through each row. This covers every bypass and target combination, including a configuration target on a remote tile. A classifier that ignored bypass, or that compared against the wrong tile, would put traffic in the wrong queue. The bench also fills the memory queue and then holds a fifth request at its input. An overflow would overwrite the head, and a shared ready would stall the message-buffer request that follows. Finally, a map write and a request to the same row are made to coincide, which exposes a map that forwards writes combinationally.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
    localparam int CA_W   = 32;
    localparam int IDX_W  = 8;
    localparam int LOW_W  = CA_W - IDX_W;
    localparam int PFX_W  = 10;
    localparam int SA_W   = PFX_W + LOW_W;
    localparam int DEST_W = 8;
    localparam int SUB_W  = 3;
    localparam int NQ     = 3;

    typedef enum logic [SUB_W-1:0] {
        SUB_CORE0 = 3'd0, SUB_CORE1 = 3'd1, SUB_CFG   = 3'd2, SUB_MBUF  = 3'd3,
        SUB_EAST  = 3'd4, SUB_SOUTH = 3'd5, SUB_WEST  = 3'd6, SUB_NORTH = 3'd7
    } sub_e;

    typedef enum logic [1:0] {
        Q_DRAM = 2'd0, Q_MBUF = 2'd1, Q_CFG = 2'd2
    } qsel_e;

    typedef struct packed {
        logic              bypass;
        logic [DEST_W-1:0] dest;
        sub_e              sub;
        logic [PFX_W-1:0]  pfx;
    } map_entry_t;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        sub_e              sub;
        logic [SA_W-1:0]   addr;
    } xreq_t;

    localparam int XW = $bits(xreq_t);
endpackage

// File: rtl/xlat_map_table.sv
`timescale 1ns/1ps
module xlat_map_table
    import xlat_pkg::*;
#(
    parameter int AW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  map_entry_t    wr_entry,
    input  logic [AW-1:0] rd_idx,
    output map_entry_t    rd_entry
);
    localparam int DEPTH = 1 << AW;

    map_entry_t tbl_d [DEPTH];
    map_entry_t tbl_q [DEPTH];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_entry = tbl_q[rd_idx];

    // R10: a row written last cycle reads back its new contents now
    assert_write_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_idx != $past(wr_idx)) || (rd_entry == $past(wr_entry)));
endmodule

// File: rtl/xlat_classify.sv
`timescale 1ns/1ps
module xlat_classify
    import xlat_pkg::*;
#(
    parameter logic [DEST_W-1:0] LOCAL_TILE = 8'h12
) (
    input  map_entry_t        ent,
    input  logic [LOW_W-1:0]  low,
    output qsel_e             qsel,
    output xreq_t             xr
);
    always_comb begin
        xr.addr = {ent.pfx, low};
        xr.sub  = ent.sub;
        xr.dest = ent.bypass ? LOCAL_TILE : ent.dest;
        if (ent.bypass || ent.sub == SUB_MBUF) begin
            qsel = Q_MBUF;
        end else if (ent.sub == SUB_CFG && ent.dest == LOCAL_TILE) begin
            qsel = Q_CFG;
        end else begin
            qsel = Q_DRAM;
        end
    end
endmodule

// File: rtl/xlat_fifo.sv
`timescale 1ns/1ps
module xlat_fifo #(
    parameter int W     = 45,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t         ctl_d, ctl_q;
    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];
    logic         pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop = out_valid && out_ready;

    always_comb begin
        ctl_d = ctl_q;
        mem_d = mem_q;
        if (push) begin
            mem_d[ctl_q.wr] = push_data;
            ctl_d.wr        = step(ctl_q.wr);
        end
        if (pop) begin
            ctl_d.rd = step(ctl_q.rd);
        end
        case ({push, pop})
            2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
            2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
            default: ctl_d.cnt = ctl_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            ctl_q <= ctl_d;
            mem_q <= mem_d;
        end
    end

    assign full      = (ctl_q.cnt == CW'(DEPTH));
    assign out_valid = (ctl_q.cnt != '0);
    assign out_data  = mem_q[ctl_q.rd];

    // R8: the upstream gate never writes into a full queue
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R9: a stalled head stays put and stays valid
    assert_head_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/addr_xlate_unit.sv
`timescale 1ns/1ps
module addr_xlate_unit
    import xlat_pkg::*;
#(
    parameter logic [DEST_W-1:0] LOCAL_TILE = 8'h12,
    parameter int                QDEPTH     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic              tbl_bypass,
    input  logic [DEST_W-1:0] tbl_dest,
    input  logic [SUB_W-1:0]  tbl_sub,
    input  logic [PFX_W-1:0]  tbl_pfx,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CA_W-1:0]   req_addr,
    output logic              dram_valid,
    input  logic              dram_ready,
    output logic [DEST_W-1:0] dram_dest,
    output logic [SUB_W-1:0]  dram_sub,
    output logic [SA_W-1:0]   dram_addr,
    output logic              mbuf_valid,
    input  logic              mbuf_ready,
    output logic [DEST_W-1:0] mbuf_dest,
    output logic [SUB_W-1:0]  mbuf_sub,
    output logic [SA_W-1:0]   mbuf_addr,
    output logic              cfg_valid,
    input  logic              cfg_ready,
    output logic [DEST_W-1:0] cfg_dest,
    output logic [SUB_W-1:0]  cfg_sub,
    output logic [SA_W-1:0]   cfg_addr
);
    map_entry_t        wr_ent, rd_ent;
    qsel_e             qsel;
    xreq_t             xr;
    logic [NQ-1:0]     q_push, q_full, q_ovalid, q_oready;
    logic [XW-1:0]     q_odata [NQ];
    xreq_t             head_dram, head_mbuf, head_cfg;

    assign wr_ent.bypass = tbl_bypass;
    assign wr_ent.dest   = tbl_dest;
    assign wr_ent.sub    = sub_e'(tbl_sub);
    assign wr_ent.pfx    = tbl_pfx;

    xlat_map_table #(.AW(IDX_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_entry (wr_ent),
        .rd_idx   (req_addr[CA_W-1 -: IDX_W]),
        .rd_entry (rd_ent)
    );

    xlat_classify #(.LOCAL_TILE(LOCAL_TILE)) u_cls (
        .ent  (rd_ent),
        .low  (req_addr[LOW_W-1:0]),
        .qsel (qsel),
        .xr   (xr)
    );

    always_comb begin
        case (qsel)
            Q_DRAM:  req_ready = !q_full[0];
            Q_MBUF:  req_ready = !q_full[1];
            default: req_ready = !q_full[2];
        endcase
    end

    assign q_oready = {cfg_ready, mbuf_ready, dram_ready};

    for (genvar gi = 0; gi < NQ; gi++) begin : g_q
        assign q_push[gi] = req_valid && req_ready && (qsel == qsel_e'(gi));
        xlat_fifo #(.W(XW), .DEPTH(QDEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (q_push[gi]),
            .push_data (xr),
            .full      (q_full[gi]),
            .out_valid (q_ovalid[gi]),
            .out_ready (q_oready[gi]),
            .out_data  (q_odata[gi])
        );
    end

    assign head_dram = xreq_t'(q_odata[0]);
    assign head_mbuf = xreq_t'(q_odata[1]);
    assign head_cfg  = xreq_t'(q_odata[2]);

    assign dram_valid = q_ovalid[0];
    assign dram_dest  = head_dram.dest;
    assign dram_sub   = head_dram.sub;
    assign dram_addr  = head_dram.addr;
    assign mbuf_valid = q_ovalid[1];
    assign mbuf_dest  = head_mbuf.dest;
    assign mbuf_sub   = head_mbuf.sub;
    assign mbuf_addr  = head_mbuf.addr;
    assign cfg_valid  = q_ovalid[2];
    assign cfg_dest   = head_cfg.dest;
    assign cfg_sub    = head_cfg.sub;
    assign cfg_addr   = head_cfg.addr;

    // R7: each handshake lands in exactly one queue, and nothing else pushes
    assert_single_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q_push) == ((req_valid && req_ready) ? 1 : 0));

    // R4: a bypass row produces a message-buffer head next cycle
    assert_bypass_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && rd_ent.bypass) |=> mbuf_valid);
endmodule

// File: tb/sim_addr_xlate_unit.sv
`timescale 1ns/1ps
module sim_addr_xlate_unit;
    localparam logic [7:0] LT = 8'h12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_idx = '0;
    logic        tbl_bypass = 1'b0;
    logic [7:0]  tbl_dest = '0;
    logic [2:0]  tbl_sub = '0;
    logic [9:0]  tbl_pfx = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        dram_valid, mbuf_valid, cfg_valid;
    logic        dram_ready = 1'b1, mbuf_ready = 1'b1, cfg_ready = 1'b1;
    logic [7:0]  dram_dest, mbuf_dest, cfg_dest;
    logic [2:0]  dram_sub, mbuf_sub, cfg_sub;
    logic [33:0] dram_addr, mbuf_addr, cfg_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    addr_xlate_unit #(.LOCAL_TILE(LT), .QDEPTH(4)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {valid, dest, sub, addr} of queue q
    function automatic logic [45:0] head(input int q);
        case (q)
            0:       return {dram_valid, dram_dest, dram_sub, dram_addr};
            1:       return {mbuf_valid, mbuf_dest, mbuf_sub, mbuf_addr};
            default: return {cfg_valid, cfg_dest, cfg_sub, cfg_addr};
        endcase
    endfunction

    task automatic check_head(input int q, input logic [7:0] d, input logic [2:0] s,
                              input logic [33:0] a, input string tag);
        logic [45:0] exp;
        exp = {1'b1, d, s, a};
        chk(head(q) == exp, tag, 64'(head(q)), 64'(exp));
    endtask

    task automatic wr_row(input logic [7:0] i, input logic b, input logic [7:0] d,
                          input logic [2:0] s, input logic [9:0] p);
        tbl_we = 1'b1; tbl_idx = i; tbl_bypass = b; tbl_dest = d; tbl_sub = s; tbl_pfx = p;
        @(posedge clk); @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] a);
        req_valid = 1'b1; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [21:0] row_of(input logic [7:0] i);
        logic b; logic [7:0] d; logic [2:0] s; logic [9:0] p;
        b = (i % 7) == 0;
        s = i[2:0];
        d = i[3] ? LT : (i ^ 8'h5A);
        p = {i, i[1:0]};
        return {b, d, s, p};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk({dram_valid, mbuf_valid, cfg_valid} == 3'b000, "R1 queues empty",
            64'({dram_valid, mbuf_valid, cfg_valid}), 64'(0));
        chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'(1));
        send(32'hAB12_3456);
        check_head(0, 8'h00, 3'd0, {10'h0, 24'h123456}, "R1 zero row to memory");
        @(posedge clk); @(negedge clk);

        // load every row
        for (int i = 0; i < 256; i++) begin
            logic [21:0] r;
            r = row_of(8'(i));
            wr_row(8'(i), r[21], r[20:13], r[12:10], r[9:0]);
        end

        // sweep: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 256; i++) begin
            logic [21:0] r; logic [23:0] lo; int q; logic [7:0] ed;
            r  = row_of(8'(i));
            lo = {8'(i), ~8'(i), 8'(i + 8'h3C)};
            if (r[21])                                   begin q = 1; ed = LT; end
            else if (r[12:10] == 3'd3)                   begin q = 1; ed = r[20:13]; end
            else if (r[12:10] == 3'd2 && r[20:13] == LT) begin q = 2; ed = r[20:13]; end
            else                                         begin q = 0; ed = r[20:13]; end
            send({8'(i), lo});
            chk({cfg_valid, mbuf_valid, dram_valid} == 3'(1 << q), "R4/R5/R6/R7 queue select",
                64'({cfg_valid, mbuf_valid, dram_valid}), 64'(1 << q));
            check_head(q, ed, r[12:10], {r[9:0], lo}, "R2/R3 fields");
            @(posedge clk); @(negedge clk);
        end

        // R10: write and request to the same row in one cycle
        dram_ready = 1'b0; mbuf_ready = 1'b0; cfg_ready = 1'b0;
        wr_row(8'h09, 1'b0, 8'h33, 3'd0, 10'h155);
        tbl_we = 1'b1; tbl_idx = 8'h09; tbl_bypass = 1'b1; tbl_dest = 8'h77; tbl_sub = 3'd0; tbl_pfx = 10'h0AA;
        req_valid = 1'b1; req_addr = 32'h0900_0111;
        @(posedge clk); @(negedge clk);
        tbl_we = 1'b0; req_addr = 32'h0900_0222;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check_head(0, 8'h33, 3'd0, {10'h155, 24'h000111}, "R10 old row used");
        check_head(1, LT, 3'd0, {10'h0AA, 24'h000222}, "R10 new row used");
        dram_ready = 1'b1; mbuf_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        dram_ready = 1'b0; mbuf_ready = 1'b0;

        // R8 / R9: fill memory queue
        wr_row(8'h10, 1'b0, 8'h44, 3'd4, 10'h3FF);
        wr_row(8'h11, 1'b0, 8'h21, 3'd3, 10'h001);
        wr_row(8'h12, 1'b0, LT, 3'd2, 10'h002);
        for (int k = 0; k < 4; k++) send(32'h1000_0100 + 32'(k));
        req_valid = 1'b1; req_addr = 32'h1000_00FF;
        #1;
        chk(req_ready == 1'b0, "R8 ready low when full", 64'(req_ready), 64'(0));
        @(posedge clk); @(negedge clk);
        check_head(0, 8'h44, 3'd4, {10'h3FF, 24'h000100}, "R8 full queue not written");
        req_addr = 32'h1100_0ABC;
        #1;
        chk(req_ready == 1'b1, "R8 other queue accepts", 64'(req_ready), 64'(1));
        @(posedge clk); @(negedge clk);
        req_addr = 32'h1200_0DEF;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check_head(1, 8'h21, 3'd3, {10'h001, 24'h000ABC}, "R5 message target");
        check_head(2, LT, 3'd2, {10'h002, 24'h000DEF}, "R6 local config");
        dram_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            check_head(0, 8'h44, 3'd4, {10'h3FF, 24'h000100 + 24'(k)}, "R9 order");
            @(posedge clk); @(negedge clk);
        end
        chk(dram_valid == 1'b0, "R8 drained", 64'(dram_valid), 64'(0));
        req_addr = 32'h1000_0000;
        #1;
        chk(req_ready == 1'b1, "R8 ready back", 64'(req_ready), 64'(1));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule